// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a register bus and an embedded flash array. A control word goes through a decoder that splits it into stored configuration bits (select, function, write enable, read-latch view, protect, an extra select bit) and self-clearing actions: preset the page buffer, clear it, request an operation and request a protection load. Bus writes into the array address space land in a page-wide write buffer and record which sector and page they aimed at. The array itself is a small behavioural memory.

A program request starts one of two operations. With the function bit clear, it erases the sector that was last addressed. With the function bit set, it programs the buffered page into the page that was last addressed. The block pulses a start line to an external timing generator and waits for that generator to report expiry. The array is updated on the expiry cycle. Sector protection lives in a separate block. The sequencer names the targeted sector to it, reads back a locked flag, and can push a new lock setting. Software observes progress through a status word with done, grant, ready, error and idle bits.

Top module: `flash_seq_top`

## Requirements
- R1: After reset the control word reads 0x0005, the status word reads 0x0045, `tmr_start` is low and every array word reads all ones.
- R2: The control word stores only bits 0, 1, 2, 5, 7 and 11. The action bits 10, 12, 14 and 15 always read back as zero. Status bit 2 (ready) equals control bit 0 (select) while no operation is in progress, and status bit 6 (idle) is set whenever no operation is in progress.
- R3: A bus write into array space stores the data in the buffer word chosen by the low address bits. It also records the sector and page fields of that address as the target. While control bit 5 is set, array-space reads return buffer words instead of array words.
- R4: A control write with bit 10 set together with bits 0, 1 and 2 presets every buffer word to all ones. If any of those four bits is missing, the buffer is unchanged.
- R5: A control write with bit 14 and bit 0 set clears every buffer word to zero.
- R6: A control write with bits 12, 7 and 0 set, issued while idle with the target sector unlocked, starts an operation. `tmr_start` is high for exactly the following cycle and `tmr_erase` equals the inverse of bit 1. The status then reads done 0 and grant (bit 1) 1.
- R7: When `tmr_expired` is high during an operation, done is 1 and grant is 0 from the next cycle on, and the array holds the result.
- R8: A page program replaces each word of the target page by its bitwise AND with the matching buffer word, so bits only fall from 1 to 0.
- R9: An erase sets every word of the target sector to all ones and leaves all other sectors unchanged.
- R10: If `lock_locked` is high when a request is accepted, no operation starts, the array is unchanged and status bit 5 (error) sets. The error bit clears when an operation is next started.
- R11: During an operation, further program requests, buffer writes and buffer fills have no effect.
- R12: A control write with bits 15 and 0 set, while idle, pulses `lock_load` for one cycle. `lock_set` carries bit 0 of buffer word 0, and `lock_sector` carries the target sector.
- R13: `tmr_expired` while idle changes neither the status word nor the array.
- R14: A program request written without bit 7 or without bit 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current bus cycle |
| bus_reg | input | 1 | 1 selects register space, 0 selects array space |
| bus_addr | input | ADDR_W | Word address: {sector, page, word}; in register space, bit 0 picks control (0) or status (1) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for the addressed location |
| tmr_start | output | 1 | One-cycle pulse that starts the external timing generator |
| tmr_erase | output | 1 | Operation kind for the timer: 1 erase, 0 program |
| tmr_expired | input | 1 | Timer reports the operation time has elapsed |
| lock_sector | output | SEC_W | Sector currently targeted, sent to the protection block |
| lock_set | output | 1 | New lock value sent with `lock_load` |
| lock_load | output | 1 | One-cycle pulse that writes `lock_set` for `lock_sector` |
| lock_locked | input | 1 | Protection block reports that `lock_sector` is locked |

## Verification
The bench writes a distinct pattern to every page of a four-sector array and programs each one. It then programs one page a second time and erases two sectors, comparing every word against a model after each step. A design that overwrote instead of ANDing, or erased the wrong sector or only one page, shows up there. It also issues a second request and buffer writes in the middle of an operation, which catches a sequencer that restarts the timer or lets the buffer change under a pending program. A request to a locked sector must leave the array intact and set error, and a later valid start must clear it. The bench also tests partial preset commands, idle expiry and requests missing select or protect, each of which a loose decoder would wrongly act on.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    // control word bit positions
    localparam int CTL_SEL     = 0;
    localparam int CTL_FUNC    = 1;
    localparam int CTL_WEN     = 2;
    localparam int CTL_RDVIEW  = 5;
    localparam int CTL_ARM     = 7;
    localparam int CTL_PRESET  = 10;
    localparam int CTL_AUXSEL  = 11;
    localparam int CTL_GO      = 12;
    localparam int CTL_WIPE    = 14;
    localparam int CTL_LOCKLD  = 15;

    // status word bit positions
    localparam int STS_DONE    = 0;
    localparam int STS_GRANT   = 1;
    localparam int STS_READY   = 2;
    localparam int STS_ERR     = 5;
    localparam int STS_IDLE    = 6;

    localparam logic [15:0] CTL_RESET_VAL = 16'h0005;
    localparam logic [15:0] CTL_KEEP_MASK = 16'h08A7;

    typedef struct packed {
        logic        fill_ones;
        logic        fill_zero;
        logic        go_req;
        logic        lock_req;
        logic [15:0] ctrl_next;
    } ctl_act_t;

endpackage

// File: rtl/fsq_ctl_decode.sv
module fsq_ctl_decode
    import fsq_pkg::*;
(
    input  logic        wr,
    input  logic [15:0] wdata,
    output ctl_act_t    act
);

    always_comb begin
        act           = '0;
        act.ctrl_next = wdata & CTL_KEEP_MASK;
        act.fill_ones = wr & wdata[CTL_PRESET] & wdata[CTL_SEL]
                           & wdata[CTL_WEN] & wdata[CTL_FUNC];
        act.fill_zero = wr & wdata[CTL_WIPE] & wdata[CTL_SEL];
        act.go_req    = wr & wdata[CTL_GO] & wdata[CTL_SEL] & wdata[CTL_ARM];
        act.lock_req  = wr & wdata[CTL_LOCKLD] & wdata[CTL_SEL];
    end

endmodule

// File: rtl/fsq_page_latch.sv
module fsq_page_latch #(
    parameter  int DATA_W     = 32,
    parameter  int PAGE_WORDS = 128,
    localparam int WD_W       = $clog2(PAGE_WORDS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 hold,
    input  logic                                 fill_ones,
    input  logic                                 fill_zero,
    input  logic                                 wr_en,
    input  logic [WD_W-1:0]                      wr_idx,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [PAGE_WORDS-1:0][DATA_W-1:0]    page
);

    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (!hold) begin
                if (fill_ones)
                    word_d = '1;
                else if (fill_zero)
                    word_d = '0;
                else if (wr_en && wr_idx == WD_W'(i))
                    word_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '1;
            else        word_q <= word_d;
        end

        assign page[i] = word_q;
    end

endmodule

// File: rtl/fsq_cell_array.sv
module fsq_cell_array #(
    parameter  int DATA_W           = 32,
    parameter  int PAGE_WORDS       = 128,
    parameter  int PAGES_PER_SECTOR = 4,
    parameter  int SECTORS          = 2,
    localparam int WD_W             = $clog2(PAGE_WORDS),
    localparam int PG_W             = $clog2(PAGES_PER_SECTOR),
    localparam int SEC_W            = $clog2(SECTORS),
    localparam int ADDR_W           = SEC_W + PG_W + WD_W,
    localparam int TOTAL            = SECTORS * PAGES_PER_SECTOR * PAGE_WORDS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              upd,
    input  logic                              upd_erase,
    input  logic [SEC_W-1:0]                  upd_sec,
    input  logic [PG_W-1:0]                   upd_pg,
    input  logic [PAGE_WORDS-1:0][DATA_W-1:0] page_in,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data
);

    logic [TOTAL-1:0][DATA_W-1:0] cells;

    for (genvar i = 0; i < TOTAL; i++) begin : g_cell
        localparam logic [SEC_W-1:0] MY_SEC = SEC_W'(i >> (PG_W + WD_W));
        localparam logic [PG_W-1:0]  MY_PG  = PG_W'(i >> WD_W);
        localparam int               MY_W   = i % PAGE_WORDS;

        logic [DATA_W-1:0] cell_d, cell_q;
        logic              hit_sec, hit_pg;

        assign hit_sec = (upd_sec == MY_SEC);
        assign hit_pg  = hit_sec && (upd_pg == MY_PG);

        always_comb begin
            cell_d = cell_q;
            if (upd && hit_sec) begin
                if (upd_erase)
                    cell_d = '1;
                else if (hit_pg)
                    cell_d = cell_q & page_in[MY_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '1;
            else        cell_q <= cell_d;
        end

        assign cells[i] = cell_q;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
    import fsq_pkg::*;
#(
    parameter  int DATA_W           = 32,
    parameter  int PAGE_WORDS       = 128,
    parameter  int PAGES_PER_SECTOR = 4,
    parameter  int SECTORS          = 2,
    localparam int WD_W             = $clog2(PAGE_WORDS),
    localparam int PG_W             = $clog2(PAGES_PER_SECTOR),
    localparam int SEC_W            = $clog2(SECTORS),
    localparam int ADDR_W           = SEC_W + PG_W + WD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_reg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tmr_start,
    output logic              tmr_erase,
    input  logic              tmr_expired,
    output logic [SEC_W-1:0]  lock_sector,
    output logic              lock_set,
    output logic              lock_load,
    input  logic              lock_locked
);

    typedef struct packed {
        logic [15:0]      ctrl;
        logic             busy;
        logic             done;
        logic             err;
        logic             tstart;
        logic             terase;
        logic             lload;
        logic             lset;
        logic [SEC_W-1:0] sec;
        logic [PG_W-1:0]  pg;
    } seq_t;

    localparam seq_t SEQ_RESET = '{ctrl: CTL_RESET_VAL, done: 1'b1, default: '0};

    seq_t st_d, st_q;

    logic                              ctrl_wr, arr_wr;
    logic [WD_W-1:0]                   a_word;
    logic [PG_W-1:0]                   a_pg;
    logic [SEC_W-1:0]                  a_sec;
    ctl_act_t                          act;
    logic [PAGE_WORDS-1:0][DATA_W-1:0] page_w;
    logic [DATA_W-1:0]                 arr_rd;
    logic [15:0]                       status_w;
    logic                              busy_w, done_w, err_w;

    assign ctrl_wr = bus_we & bus_reg & ~bus_addr[0];
    assign arr_wr  = bus_we & ~bus_reg;
    assign a_word  = bus_addr[WD_W-1:0];
    assign a_pg    = bus_addr[WD_W +: PG_W];
    assign a_sec   = bus_addr[WD_W+PG_W +: SEC_W];

    fsq_ctl_decode u_dec (
        .wr    (ctrl_wr),
        .wdata (bus_wdata[15:0]),
        .act   (act)
    );

    fsq_page_latch #(
        .DATA_W     (DATA_W),
        .PAGE_WORDS (PAGE_WORDS)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (st_q.busy),
        .fill_ones (act.fill_ones),
        .fill_zero (act.fill_zero),
        .wr_en     (arr_wr),
        .wr_idx    (a_word),
        .wr_data   (bus_wdata),
        .page      (page_w)
    );

    fsq_cell_array #(
        .DATA_W           (DATA_W),
        .PAGE_WORDS       (PAGE_WORDS),
        .PAGES_PER_SECTOR (PAGES_PER_SECTOR),
        .SECTORS          (SECTORS)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (tmr_expired & st_q.busy),
        .upd_erase (st_q.terase),
        .upd_sec   (st_q.sec),
        .upd_pg    (st_q.pg),
        .page_in   (page_w),
        .rd_addr   (bus_addr),
        .rd_data   (arr_rd)
    );

    // next-state computation
    always_comb begin
        st_d        = st_q;
        st_d.tstart = 1'b0;
        st_d.lload  = 1'b0;

        if (ctrl_wr)
            st_d.ctrl = act.ctrl_next;

        if (arr_wr && !st_q.busy) begin
            st_d.sec = a_sec;
            st_d.pg  = a_pg;
        end

        if (act.go_req && !st_q.busy) begin
            if (lock_locked) begin
                st_d.err = 1'b1;
            end else begin
                st_d.busy   = 1'b1;
                st_d.done   = 1'b0;
                st_d.err    = 1'b0;
                st_d.tstart = 1'b1;
                st_d.terase = ~bus_wdata[CTL_FUNC];
            end
        end

        if (act.lock_req && !st_q.busy) begin
            st_d.lload = 1'b1;
            st_d.lset  = page_w[0][0];
        end

        if (tmr_expired && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        status_w            = '0;
        status_w[STS_DONE]  = st_q.done;
        status_w[STS_GRANT] = st_q.busy;
        status_w[STS_READY] = st_q.ctrl[CTL_SEL] & ~st_q.busy;
        status_w[STS_ERR]   = st_q.err;
        status_w[STS_IDLE]  = ~st_q.busy;
    end

    always_comb begin
        if (bus_reg)
            bus_rdata = DATA_W'(bus_addr[0] ? status_w : st_q.ctrl);
        else if (st_q.ctrl[CTL_RDVIEW])
            bus_rdata = page_w[a_word];
        else
            bus_rdata = arr_rd;
    end

    assign tmr_start   = st_q.tstart;
    assign tmr_erase   = st_q.terase;
    assign lock_load   = st_q.lload;
    assign lock_set    = st_q.lset;
    assign lock_sector = st_q.sec;
    assign busy_w      = st_q.busy;
    assign done_w      = st_q.done;
    assign err_w       = st_q.err;

endmodule

// File: rtl/fsq_checker.sv
module fsq_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic tmr_start,
    input logic tmr_expired
);

    a_r6_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |-> (busy && !done));

    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> !tmr_start);

    a_r7_expiry_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tmr_expired) |=> (done && !busy));

    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r10_error_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !tmr_start));

    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_expired) |=> busy);

endmodule

bind flash_seq_top fsq_checker u_fsq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy_w),
    .done        (done_w),
    .err         (err_w),
    .tmr_start   (tmr_start),
    .tmr_expired (tmr_expired)
);

// File: tb/tb_flash_seq_top.sv
`timescale 1ns/1ps
module tb_flash_seq_top;
    localparam int DW = 32, PW = 4, PPS = 2, NS = 4, AW = 5, NT = 32;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          bus_we = 1'b0, bus_reg = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          tmr_start, tmr_erase, lock_set, lock_load, lock_locked;
    logic          tmr_expired = 1'b0;
    logic [1:0]    lock_sector;
    logic [NS-1:0] locks_m = '1;
    logic [DW-1:0] mem_m [NT];
    int            checks = 0, fails = 0;
    bit            finished = 0;

    assign lock_locked = locks_m[lock_sector];

    always #2 clk = ~clk;

    flash_seq_top #(.DATA_W(DW), .PAGE_WORDS(PW), .PAGES_PER_SECTOR(PPS), .SECTORS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_reg(bus_reg), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_start(tmr_start),
        .tmr_erase(tmr_erase), .tmr_expired(tmr_expired), .lock_sector(lock_sector),
        .lock_set(lock_set), .lock_load(lock_load), .lock_locked(lock_locked));

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(bit rg, int a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_reg = rg; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(bit rg, int a, output logic [31:0] d);
        bus_reg = rg; bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    function automatic int adr(int s, int p, int w);
        return s * PPS * PW + p * PW + w;
    endfunction

    function automatic logic [31:0] pat(bit second, int s, int p, int w);
        if (second) return ~(32'h3 << (w * 5));
        return ~(32'h11 << (s * 7 + p * 3 + w));
    endfunction

    task automatic check_array(string req);
        logic [31:0] d;
        for (int i = 0; i < NT; i++) begin
            rd(0, i, d);
            chk(req, d, mem_m[i]);
        end
    endtask

    task automatic expire();
        @(negedge clk) tmr_expired = 1'b1;
        @(negedge clk) tmr_expired = 1'b0;
    endtask

    task automatic set_lock(int s, logic [31:0] v);
        wr(0, adr(s, 0, 0), v);
        wr(1, 0, 32'h8005);
        chk("R12 lock_load", 32'(lock_load), 1);
        chk("R12 lock_set", 32'(lock_set), 32'(v[0]));
        chk("R12 lock_sector", 32'(lock_sector), s);
        locks_m[s] = v[0];
    endtask

    task automatic prog_page(int s, int p, bit second, bit busy_poke);
        logic [31:0] d;
        wr(1, 0, 32'h407);
        for (int w = 0; w < PW; w++) wr(0, adr(s, p, w), pat(second, s, p, w));
        wr(1, 0, 32'h1087);
        chk("R6 tmr_start", 32'(tmr_start), 1);
        chk("R6 tmr_erase", 32'(tmr_erase), 0);
        rd(1, 1, d);
        chk("R6 status busy", d, 32'h02);
        if (busy_poke) begin
            wr(0, adr(s, p, 0), 32'h0);
            wr(1, 0, 32'h1087);
            chk("R11 no restart", 32'(tmr_start), 0);
            wr(1, 0, 32'h4085);
            rd(1, 1, d);
            chk("R11 still busy", d, 32'h02);
        end
        repeat (2) @(negedge clk);
        expire();
        rd(1, 1, d);
        chk("R7 status done", d, 32'h45);
        for (int w = 0; w < PW; w++) mem_m[adr(s, p, w)] &= pat(second, s, p, w);
        check_array("R8 program AND");
        if (busy_poke) begin
            wr(1, 0, 32'h25);
            rd(0, adr(s, p, 0), d);
            chk("R11 buffer kept", d, pat(second, s, p, 0));
            wr(1, 0, 32'h5);
        end
    endtask

    task automatic erase_sector(int s);
        logic [31:0] d;
        wr(0, adr(s, 0, 0), 32'h1234);
        wr(1, 0, 32'h1085);
        chk("R6 erase start", 32'(tmr_start), 1);
        chk("R6 erase kind", 32'(tmr_erase), 1);
        repeat (3) @(negedge clk);
        expire();
        rd(1, 1, d);
        chk("R7 erase done", d, 32'h45);
        for (int i = 0; i < PPS * PW; i++) mem_m[s * PPS * PW + i] = '1;
        check_array("R9 erase");
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NT; i++) mem_m[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1, 0, d); chk("R1 ctrl reset", d, 32'h5);
        rd(1, 1, d); chk("R1 status reset", d, 32'h45);
        chk("R1 tmr_start", 32'(tmr_start), 0);
        check_array("R1 array erased");

        // R2 stored bits only
        wr(1, 0, 32'hFFFE);
        rd(1, 0, d); chk("R2 ctrl mask", d, 32'h8A6);
        rd(1, 1, d); chk("R2 ready follows select", d, 32'h41);
        chk("R2 no action", 32'(tmr_start), 0);
        wr(1, 0, 32'h5);

        // R3 buffer writes and buffer view
        for (int w = 0; w < PW; w++) wr(0, adr(1, 1, w), 32'hA500_0000 + w);
        wr(1, 0, 32'h25);
        for (int w = 0; w < PW; w++) begin
            rd(0, adr(2, 0, w), d); chk("R3 buffer view", d, 32'hA500_0000 + w);
        end
        chk("R3 target sector", 32'(lock_sector), 1);

        // R4 preset needs all four bits
        wr(1, 0, 32'h425);
        rd(0, 0, d); chk("R4 partial preset ignored", d, 32'hA500_0000);
        wr(1, 0, 32'h427);
        for (int w = 0; w < PW; w++) begin
            rd(0, w, d); chk("R4 preset ones", d, 32'hFFFF_FFFF);
        end

        // R5 clear buffer
        wr(1, 0, 32'h4025);
        for (int w = 0; w < PW; w++) begin
            rd(0, w, d); chk("R5 cleared", d, 32'h0);
        end
        wr(1, 0, 32'h5);

        // R12 unlock all sectors
        for (int s = 0; s < NS; s++) set_lock(s, 32'h0);

        // R8 sweep every page
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < PPS; p++) prog_page(s, p, 1'b0, 1'b0);

        // R8 second program on same page, with R11 pokes while busy
        prog_page(0, 1, 1'b1, 1'b1);

        // R9 erase two sectors
        erase_sector(1);
        erase_sector(3);

        // R10 locked sector
        set_lock(2, 32'h1);
        wr(1, 0, 32'h407);
        for (int w = 0; w < PW; w++) wr(0, adr(2, 0, w), 32'h0);
        wr(1, 0, 32'h1087);
        chk("R10 no start", 32'(tmr_start), 0);
        rd(1, 1, d); chk("R10 error set", d, 32'h65);
        expire();
        check_array("R10 array untouched");
        prog_page(0, 0, 1'b1, 1'b0);
        rd(1, 1, d); chk("R10 error cleared", d, 32'h45);

        // R13 idle expiry
        expire();
        rd(1, 1, d); chk("R13 status unchanged", d, 32'h45);
        check_array("R13 array unchanged");

        // R14 missing protect or select
        wr(0, adr(3, 0, 0), 32'h0);
        wr(1, 0, 32'h1007);
        chk("R14 no protect", 32'(tmr_start), 0);
        rd(1, 1, d); chk("R14 status no protect", d, 32'h45);
        wr(1, 0, 32'h1086);
        chk("R14 no select", 32'(tmr_start), 0);
        rd(1, 1, d); chk("R14 status no select", d, 32'h41);
        wr(1, 0, 32'h5);
        check_array("R14 array unchanged");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule